// File: doc/BRIEF.md
# DMA Descriptor Ring Pointer Manager

This block keeps the four pointers of one circular DMA queue held in memory: the lower bound, the upper bound, the consume pointer (head) and the produce pointer (tail). All four count in 16-byte units, so an address shifted right by four bits is stored. A descriptor occupies 32 bytes, which moves a pointer by two units. Software sets up and inspects the queue through a small register port. A descriptor engine outside the block trades entries with it through a valid/ready handshake that carries the pointer the engine should use next.

The block runs in one of two directions. In injection mode software produces entries by writing the tail, and the engine drains them from head up to, but not including, tail, moving head on every completed handshake. In reception mode the roles swap: the engine fills entries and moves tail, and software frees them by writing head. Occupancy is turned into a free-space count and an empty flag. A pointer that steps onto or past the upper bound folds back to the lower bound in the same cycle.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset every register reads 0 (control, bounds, head, tail, free space, size), queueEmpty is 1, errFlag is 0 and engValid is 0.
- R2: Register addresses are control=0, start=1, end=2, head=3, tail=4, free space=5 (read-only), size=6 (read-only). A write takes effect at the clock edge that samples it. regRdata shows the addressed register combinationally. The control word is bit 0 enable, bit 1 mode (1 = reception, 0 = injection) and bit 2 error flag. Writing control with bit 2 set clears the error flag.
- R3: Size equals end − start. Free space equals size − (tail − head) when tail ≥ head, and head − tail otherwise.
- R4: queueEmpty is 1 exactly when head equals tail. When the queue is empty, free space equals size.
- R5: In injection mode with enable set, engValid is high exactly when the queue is not empty, and engAddr shows head. Head moves by 2 only on a cycle where engValid and engReady are both high. Otherwise engAddr holds.
- R6: When a step of 2 brings a pointer to or beyond end, the pointer becomes start plus the overshoot, in the same update.
- R7: In reception mode with enable set, engValid is high exactly when free space exceeds 2, and engAddr shows tail. Tail moves by 2 on each completed handshake.
- R8: While enable is set, writes to start, end and the pointer the engine owns (head in injection mode, tail in reception mode) are ignored.
- R9: While enable is set, a write of the value end to the software-owned pointer stores start instead.
- R10: While enable is set, a software pointer write is rejected, and the error flag is set, in two cases. The first is a value outside [start, end]. The second, in injection mode only, is a tail value that would equal head (after the R9 fold) while the queue is not empty. The flag stays set until it is cleared through control.
- R11: While enable is clear, engValid is 0 and writes to start, end, head and tail are stored verbatim, with no fold and no check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | PTR_W | Register write data |
| regRdata | output | PTR_W | Read data of the addressed register |
| engValid | output | 1 | An entry is offered to the engine |
| engReady | input | 1 | Engine accepts the offered entry |
| engAddr | output | PTR_W | Pointer the engine works on, in 16-byte units |
| freeSpace | output | PTR_W | Free space in 16-byte units |
| queueEmpty | output | 1 | Head equals tail |
| errFlag | output | 1 | Sticky rejected-write flag |

## Verification
The bench drives a queue to full drain in injection mode and checks that head folds back to start exactly at the end bound. A design that compared with > instead of ≥, or that dropped the overshoot, would hand the engine an address outside the queue. A reception run uses an odd-sized queue so that the fold lands off-grid, and it confirms that the engine stops offering entries once only one free unit would be left. Writes aimed at the engine-owned pointer and at the bounds while enabled are read back to prove they were discarded. A tail write that would make the queue look empty while it holds entries must be refused with the error flag set, because accepting it would silently lose the pending descriptors.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_START = 3'd1;
  localparam logic [ADDR_W-1:0] RA_END   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_HEAD  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_TAIL  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_FREE  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_SIZE  = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic ldStart;
    logic ldEnd;
    logic ldHead;
    logic ldTail;
    logic useWrap;
    logic advHead;
    logic advTail;
  } ptrStrobe_t;
endpackage

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
  parameter int PTR_W = 16,
  parameter int STEP  = 2
) (
  input  logic [PTR_W-1:0] ptrQ,
  input  logic [PTR_W-1:0] endQ,
  input  logic [PTR_W-1:0] sizeQ,
  output logic [PTR_W-1:0] nextPtr
);
  localparam logic [PTR_W:0] STEP_EXT = (PTR_W+1)'(STEP);

  logic [PTR_W:0] sum;
  logic [PTR_W:0] folded;
  logic           wrapNeeded;

  always_comb begin
    sum        = {1'b0, ptrQ} + STEP_EXT;
    wrapNeeded = sum >= {1'b0, endQ};
    folded     = sum - {1'b0, sizeQ};
    nextPtr    = wrapNeeded ? folded[PTR_W-1:0] : sum[PTR_W-1:0];
  end
endmodule

// File: rtl/ring_ptr_dp.sv
module ring_ptr_dp
  import ring_ptr_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int DESC_UNITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobe_t        stb,
  input  logic [PTR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              enableQ,
  input  logic              recvMode,
  input  logic              errQ,
  output logic [PTR_W-1:0]  headQ,
  output logic [PTR_W-1:0]  tailQ,
  output logic [PTR_W-1:0]  sizeQ,
  output logic [PTR_W-1:0]  freeSpace,
  output logic              emptyQ,
  output logic              wrInRange,
  output logic              wrHitsHead,
  output logic [PTR_W-1:0]  rdData
);
  logic [PTR_W-1:0] startQ;
  logic [PTR_W-1:0] endQ;
  logic [PTR_W-1:0] wrFixed;
  logic [PTR_W-1:0] headNext;
  logic [PTR_W-1:0] tailNext;

  assign sizeQ = endQ - startQ;

  ring_ptr_step #(.PTR_W(PTR_W), .STEP(DESC_UNITS)) u_headStep (
    .ptrQ(headQ), .endQ(endQ), .sizeQ(sizeQ), .nextPtr(headNext)
  );
  ring_ptr_step #(.PTR_W(PTR_W), .STEP(DESC_UNITS)) u_tailStep (
    .ptrQ(tailQ), .endQ(endQ), .sizeQ(sizeQ), .nextPtr(tailNext)
  );

  always_comb begin
    wrFixed    = (wrData == endQ) ? startQ : wrData;
    wrInRange  = (wrData >= startQ) && (wrData <= endQ);
    wrHitsHead = (wrFixed == headQ);
    emptyQ     = (headQ == tailQ);
    if (tailQ >= headQ) freeSpace = sizeQ - (tailQ - headQ);
    else                freeSpace = headQ - tailQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      endQ   <= '0;
      headQ  <= '0;
      tailQ  <= '0;
    end else begin
      if (stb.ldStart) startQ <= wrData;
      if (stb.ldEnd)   endQ   <= wrData;
      if (stb.ldHead)       headQ <= stb.useWrap ? wrFixed : wrData;
      else if (stb.advHead) headQ <= headNext;
      if (stb.ldTail)       tailQ <= stb.useWrap ? wrFixed : wrData;
      else if (stb.advTail) tailQ <= tailNext;
    end
  end

  always_comb begin
    case (rdAddr)
      RA_CTRL:  rdData = {{(PTR_W-3){1'b0}}, errQ, recvMode, enableQ};
      RA_START: rdData = startQ;
      RA_END:   rdData = endQ;
      RA_HEAD:  rdData = headQ;
      RA_TAIL:  rdData = tailQ;
      RA_FREE:  rdData = freeSpace;
      RA_SIZE:  rdData = sizeQ;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int DESC_UNITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0]        ctrlBits,
  input  logic              engReady,
  input  logic              emptyQ,
  input  logic [PTR_W-1:0]  freeSpace,
  input  logic              wrInRange,
  input  logic              wrHitsHead,
  output ptrStrobe_t        stb,
  output logic              enableQ,
  output logic              recvMode,
  output logic              errQ,
  output logic              engValid
);
  localparam logic [PTR_W-1:0] DESC_VAL = PTR_W'(DESC_UNITS);

  logic setErr;
  logic ctrlWr;

  assign ctrlWr = regWe && (regAddr == RA_CTRL);

  always_comb begin
    if (!enableQ)     engValid = 1'b0;
    else if (recvMode) engValid = freeSpace > DESC_VAL;
    else              engValid = !emptyQ;
  end

  always_comb begin
    stb         = '0;
    setErr      = 1'b0;
    stb.advHead = engValid && engReady && !recvMode;
    stb.advTail = engValid && engReady && recvMode;
    if (regWe) begin
      if (!enableQ) begin
        case (regAddr)
          RA_START: stb.ldStart = 1'b1;
          RA_END:   stb.ldEnd   = 1'b1;
          RA_HEAD:  stb.ldHead  = 1'b1;
          RA_TAIL:  stb.ldTail  = 1'b1;
          default:  ;
        endcase
      end else begin
        stb.useWrap = 1'b1;
        if (regAddr == RA_TAIL && !recvMode) begin
          if (wrInRange && !(wrHitsHead && !emptyQ)) stb.ldTail = 1'b1;
          else                                       setErr     = 1'b1;
        end else if (regAddr == RA_HEAD && recvMode) begin
          if (wrInRange) stb.ldHead = 1'b1;
          else           setErr     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      recvMode <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enableQ  <= ctrlBits[0];
        recvMode <= ctrlBits[1];
        if (ctrlBits[2]) errQ <= 1'b0;
      end
      if (setErr) errQ <= 1'b1;
    end
  end
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ring_ptr_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int DESC_UNITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PTR_W-1:0]  regWdata,
  output logic [PTR_W-1:0]  regRdata,
  output logic              engValid,
  input  logic              engReady,
  output logic [PTR_W-1:0]  engAddr,
  output logic [PTR_W-1:0]  freeSpace,
  output logic              queueEmpty,
  output logic              errFlag
);
  ptrStrobe_t       stb;
  logic             enableQ;
  logic             recvMode;
  logic             errQ;
  logic             wrInRange;
  logic             wrHitsHead;
  logic [PTR_W-1:0] headQ;
  logic [PTR_W-1:0] tailQ;
  logic [PTR_W-1:0] sizeQ;

  ring_ptr_ctrl #(.PTR_W(PTR_W), .DESC_UNITS(DESC_UNITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ctrlBits(regWdata[2:0]), .engReady(engReady), .emptyQ(queueEmpty),
    .freeSpace(freeSpace), .wrInRange(wrInRange), .wrHitsHead(wrHitsHead),
    .stb(stb), .enableQ(enableQ), .recvMode(recvMode), .errQ(errQ),
    .engValid(engValid)
  );

  ring_ptr_dp #(.PTR_W(PTR_W), .DESC_UNITS(DESC_UNITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata), .rdAddr(regAddr),
    .enableQ(enableQ), .recvMode(recvMode), .errQ(errQ),
    .headQ(headQ), .tailQ(tailQ), .sizeQ(sizeQ), .freeSpace(freeSpace),
    .emptyQ(queueEmpty), .wrInRange(wrInRange), .wrHitsHead(wrHitsHead),
    .rdData(regRdata)
  );

  assign engAddr = recvMode ? tailQ : headQ;
  assign errFlag = errQ;
endmodule

// File: rtl/ring_ptr_mgr_chk.sv
module ring_ptr_mgr_chk #(
  parameter int PTR_W      = 16,
  parameter int DESC_UNITS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic             clrReq,
  input logic             engValid,
  input logic             engReady,
  input logic [PTR_W-1:0] engAddr,
  input logic [PTR_W-1:0] freeSpace,
  input logic [PTR_W-1:0] sizeQ,
  input logic             queueEmpty,
  input logic             errFlag,
  input logic             enableQ,
  input logic             recvMode
);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> !engValid);

  // R5
  empty_no_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueEmpty && !recvMode) |-> !engValid);

  // R7
  recv_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engValid && recvMode) |-> (freeSpace > PTR_W'(DESC_UNITS)));

  // R4
  empty_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueEmpty |-> (freeSpace == sizeQ));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(engValid && engReady) && !regWe) |=> $stable(engAddr));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrReq) |=> errFlag);
endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(.PTR_W(PTR_W), .DESC_UNITS(DESC_UNITS)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe),
  .clrReq(regWe && (regAddr == 3'd0) && regWdata[2]),
  .engValid(engValid), .engReady(engReady), .engAddr(engAddr),
  .freeSpace(freeSpace), .sizeQ(sizeQ), .queueEmpty(queueEmpty),
  .errFlag(errFlag), .enableQ(enableQ), .recvMode(recvMode)
);

// File: tb/ring_ptr_mgr_tb.sv
`timescale 1ns/1ps
module ring_ptr_mgr_tb;
  localparam int PTR_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWe = 1'b0;
  logic [2:0]       regAddr = '0;
  logic [PTR_W-1:0] regWdata = '0;
  logic [PTR_W-1:0] regRdata;
  logic             engValid;
  logic             engReady = 1'b0;
  logic [PTR_W-1:0] engAddr;
  logic [PTR_W-1:0] freeSpace;
  logic             queueEmpty;
  logic             errFlag;

  int nChecks = 0;
  int nFails  = 0;
  logic [PTR_W-1:0] expQ[$];

  always #4 clk = ~clk;

  ring_ptr_mgr #(.PTR_W(PTR_W), .DESC_UNITS(2)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engValid(engValid),
    .engReady(engReady), .engAddr(engAddr), .freeSpace(freeSpace),
    .queueEmpty(queueEmpty), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PTR_W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [PTR_W-1:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic expectAddr(input logic [PTR_W-1:0] a);
    expQ.push_back(a);
  endtask

  task automatic runEngine();
    @(negedge clk);
    engReady = 1'b1;
    wait (expQ.size() == 0);
    @(negedge clk);
    engReady = 1'b0;
    #1;
  endtask

  // monitor: compares every completed handshake against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rstN && engValid && engReady) begin
      if (expQ.size() == 0) chk("R5/R7 unexpected handshake", 1, 0);
      else chk("R5/R7 engine address", engAddr, expQ.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    for (int a = 0; a < 7; a++) rdChk(3'(a), '0, "R1 register after reset");
    chk("R1 empty after reset", queueEmpty, 1);
    chk("R1 error after reset", errFlag, 0);
    chk("R1 no offer after reset", engValid, 0);

    // R2 / R11: program while disabled
    wr(3'd1, 16'h0100);
    wr(3'd2, 16'h0108);
    wr(3'd3, 16'h0100);
    wr(3'd4, 16'h0108);
    rdChk(3'd4, 16'h0108, "R11 raw tail write kept verbatim");
    wr(3'd4, 16'h0100);
    rdChk(3'd1, 16'h0100, "R2 start readback");
    rdChk(3'd2, 16'h0108, "R2 end readback");
    rdChk(3'd6, 16'h0008, "R3 size");
    rdChk(3'd5, 16'h0008, "R4 free when empty");
    chk("R4 empty flag", queueEmpty, 1);

    // injection mode
    wr(3'd0, 16'h0001);
    chk("R5 no offer when empty", engValid, 0);
    wr(3'd4, 16'h0104);
    rdChk(3'd4, 16'h0104, "R2 tail readback");
    chk("R3 free tail above head", freeSpace, 16'h0004);
    chk("R5 offer when pending", engValid, 1);
    chk("R5 offered address is head", engAddr, 16'h0100);
    repeat (3) @(negedge clk);
    #1;
    chk("R5 head holds without ready", engAddr, 16'h0100);

    // R8: writes to bounds and engine-owned head ignored
    wr(3'd3, 16'h0106);
    rdChk(3'd3, 16'h0100, "R8 head write ignored");
    wr(3'd1, 16'h0000);
    rdChk(3'd1, 16'h0100, "R8 start write ignored");
    chk("R8 no error on ignored write", errFlag, 0);

    expectAddr(16'h0100);
    expectAddr(16'h0102);
    runEngine();
    rdChk(3'd3, 16'h0104, "R5 head after two consumes");
    chk("R5 empty after drain", queueEmpty, 1);
    chk("R5 no offer after drain", engValid, 0);

    // R9: tail write of end folds to start
    wr(3'd4, 16'h0108);
    rdChk(3'd4, 16'h0100, "R9 tail folded to start");
    chk("R3 free tail below head", freeSpace, 16'h0004);

    // R10 rejections
    wr(3'd4, 16'h0104);
    rdChk(3'd4, 16'h0100, "R10 full write rejected");
    chk("R10 error set on full", errFlag, 1);
    wr(3'd4, 16'h010A);
    rdChk(3'd4, 16'h0100, "R10 out-of-range write rejected");
    @(negedge clk);
    rdChk(3'd0, 16'h0005, "R10 error sticky in control word");
    wr(3'd0, 16'h0005);
    rdChk(3'd0, 16'h0001, "R10 error cleared");

    // R6: head wraps at end
    expectAddr(16'h0104);
    expectAddr(16'h0106);
    runEngine();
    rdChk(3'd3, 16'h0100, "R6 head wrapped to start");
    chk("R6 empty after wrap", queueEmpty, 1);

    // reception mode on an odd-sized queue
    wr(3'd0, 16'h0000);
    chk("R11 no offer when disabled", engValid, 0);
    wr(3'd2, 16'h0107);
    wr(3'd3, 16'h0104);
    wr(3'd4, 16'h0104);
    wr(3'd0, 16'h0003);
    rdChk(3'd5, 16'h0007, "R3 free odd size");
    chk("R7 offered address is tail", engAddr, 16'h0104);
    expectAddr(16'h0104);
    expectAddr(16'h0106);
    expectAddr(16'h0101);
    runEngine();
    rdChk(3'd4, 16'h0103, "R6 tail wrapped with overshoot");
    chk("R7 free after fills", freeSpace, 16'h0001);
    chk("R7 no offer when room too small", engValid, 0);

    wr(3'd4, 16'h0100);
    rdChk(3'd4, 16'h0103, "R8 tail write ignored in reception");
    wr(3'd3, 16'h0107);
    rdChk(3'd3, 16'h0100, "R9 head folded to start");
    chk("R7 free after head release", freeSpace, 16'h0004);
    chk("R7 offer resumes", engValid, 1);
    wr(3'd0, 16'h0000);
    chk("R11 offer stops when disabled", engValid, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule